// File: doc/BRIEF.md
# Timer-Chip Logic Cell Model

This block is a clock-driven digital model of a general-purpose timer chip used as a logic element rather than as an analog timer. Five logic-level pins drive it: an active-low clear, a control-drive enable, a control level, a threshold level and an active-low trigger. A decode stage turns these pins into a set request, a clear request or neither. The requests drive an internal set/clear state bit. The state appears on a push-pull output and on a discharge pin, which is modelled as an open-drain driver. Everything is sampled on `clk`, so the raw cell output changes one clock after its pins change.

Beside the raw cell, the block offers two uses of the same cell. The first is a transparent data latch: the control pin carries data, threshold is the enable and trigger is the enable's complement. The second is a bank of `FF_W` edge-triggered flip-flops. Each flip-flop is two such latches in series with opposite enable polarity, so it captures data on the rising edge of its sampled `ff_clk` input. A cell's clear pin and the block reset `rst_n` both force the state to 0.

Top module: `tmr_logic_model`

## Requirements
- R1: With `pin_rst_n`=0 the cell requests a clear, and `pin_out` is 0 after the next `clk` edge whatever the other four pins are.
- R2: With `pin_rst_n`=1 and `pin_ctl_en`=0: `pin_trg_n`=0 sets the state to 1 whatever `pin_thr` is; `pin_thr`=1 with `pin_trg_n`=1 clears it; `pin_thr`=0 with `pin_trg_n`=1 holds it.
- R3: With `pin_rst_n`=1, `pin_ctl_en`=1 and `pin_ctl`=0, `pin_trg_n` is ignored: `pin_thr`=1 clears the state and `pin_thr`=0 holds it.
- R4: With `pin_rst_n`=1, `pin_ctl_en`=1 and `pin_ctl`=1, `pin_thr` is ignored: `pin_trg_n`=0 sets the state and `pin_trg_n`=1 holds it.
- R5: `pin_out` shows the state, which updates on the first rising `clk` edge after the pins are applied.
- R6: `pin_dis_lvl` is 0, and `pin_dis_oe` is 1 exactly when `pin_out` is 0. A pull-up wired to the discharge pin therefore reads the same value as `pin_out`.
- R7: Latch mode: while `lat_en`=1 and `lat_clr_n`=1, `lat_q` equals the `lat_d` sampled at the previous `clk` edge.
- R8: Latch mode: while `lat_en`=0 and `lat_clr_n`=1, `lat_q` holds its value whatever `lat_d` does.
- R9: Latch mode: `lat_clr_n`=0 makes `lat_q` 0 after the next `clk` edge.
- R10: Each `ff_q` bit takes its `ff_d` bit when `ff_clk` rises, provided `ff_d` was stable and `ff_clk` was low at the `clk` edge before the rise. The new value is visible after the first `clk` edge at which `ff_clk` is high.
- R11: Apart from that capture, `ff_q` does not change while `ff_clk` stays high, stays low or falls, whatever `ff_d` does.
- R12: `ff_clr_n`=0 clears every `ff_q` bit.
- R13: `rst_n`=0 clears the raw cell, the latch and the flip-flop bank at once, without waiting for `clk`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock of the model |
| rst_n | input | 1 | Asynchronous block reset, active low |
| pin_rst_n | input | 1 | Raw cell clear pin, active low |
| pin_ctl_en | input | 1 | Raw cell: 1 when the control pin is driven |
| pin_ctl | input | 1 | Raw cell control level |
| pin_thr | input | 1 | Raw cell threshold level |
| pin_trg_n | input | 1 | Raw cell trigger, active low |
| pin_out | output | 1 | Raw cell push-pull output |
| pin_dis_oe | output | 1 | Raw cell discharge driver enable |
| pin_dis_lvl | output | 1 | Raw cell discharge drive level (always 0) |
| lat_clr_n | input | 1 | Latch clear, active low |
| lat_en | input | 1 | Latch enable (open when 1) |
| lat_d | input | 1 | Latch data |
| lat_q | output | 1 | Latch output |
| ff_clr_n | input | 1 | Flip-flop bank clear, active low |
| ff_clk | input | 1 | Flip-flop bank edge input, sampled on clk |
| ff_d | input | FF_W | Flip-flop bank data |
| ff_q | output | FF_W | Flip-flop bank outputs |

## Verification
The assertions assume that every pin is a clean logic level sampled on `clk`. The analog comparator levels, resistor dividers and the real order in which threshold and trigger change are not modelled. The latch properties assume that its enable is a single signal from which threshold and trigger are both derived. The stimulus respects this because the bench never drives the latch cells' threshold and trigger separately. All pin changes happen on the falling `clk` edge. The flip-flop stimulus holds `ff_d` stable for two `clk` cycles before each rise of `ff_clk`, so that every capture stays within the R10 setup condition.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

  typedef enum logic [1:0] {
    REQ_HOLD = 2'b00,
    REQ_SET  = 2'b01,
    REQ_CLR  = 2'b10
  } req_t;

  // Pin decode: clear pin wins, then the control drive picks which comparator counts.
  function automatic req_t tmr_decode_fn(logic clr_n, logic ce, logic c,
                                         logic thr, logic trg_n);
    req_t r;
    if (!clr_n)        r = REQ_CLR;
    else if (!ce) begin
      if (!trg_n)      r = REQ_SET;
      else if (thr)    r = REQ_CLR;
      else             r = REQ_HOLD;
    end
    else if (!c)       r = thr ? REQ_CLR : REQ_HOLD;   // trigger ignored
    else               r = trg_n ? REQ_HOLD : REQ_SET; // threshold ignored
    return r;
  endfunction

  function automatic logic tmr_next_q(logic set_req, logic clr_req, logic q);
    logic n;
    if (clr_req)      n = 1'b0;
    else if (set_req) n = 1'b1;
    else              n = q;
    return n;
  endfunction

endpackage

// File: rtl/tmr_decode.sv
module tmr_decode
  import tmr_pkg::*;
(
  input  logic clr_n,
  input  logic ctl_en,
  input  logic ctl,
  input  logic thr,
  input  logic trg_n,
  output logic set_req,
  output logic clr_req
);
  req_t req;

  always_comb begin
    req     = tmr_decode_fn(clr_n, ctl_en, ctl, thr, trg_n);
    set_req = (req == REQ_SET);
    clr_req = (req == REQ_CLR);
  end
endmodule

// File: rtl/tmr_srreg.sv
module tmr_srreg
  import tmr_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic set_req,
  input  logic clr_req,
  output logic q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= 1'b0;
    else        q <= tmr_next_q(set_req, clr_req, q);
  end
endmodule

// File: rtl/tmr_dlatch.sv
module tmr_dlatch #(
  parameter bit OPEN_HIGH = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr_n,
  input  logic en,
  input  logic d,
  output logic q
);
  logic thr_w, trg_n_w, set_w, clr_w;

  // The trigger enable is derived from the threshold enable so both come from one signal.
  generate
    if (OPEN_HIGH) begin : g_pos
      assign thr_w = en;
    end else begin : g_neg
      assign thr_w = ~en;
    end
  endgenerate
  assign trg_n_w = ~thr_w;

  tmr_decode dec_i (
    .clr_n  (clr_n),
    .ctl_en (1'b1),
    .ctl    (d),
    .thr    (thr_w),
    .trg_n  (trg_n_w),
    .set_req(set_w),
    .clr_req(clr_w)
  );

  tmr_srreg reg_i (
    .clk    (clk),
    .rst_n  (rst_n),
    .set_req(set_w),
    .clr_req(clr_w),
    .q      (q)
  );
endmodule

// File: rtl/tmr_dff_bank.sv
module tmr_dff_bank #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr_n,
  input  logic         edge_in,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] mid_q;

  generate
    for (genvar i = 0; i < W; i++) begin : g_bit
      // Front stage open while edge_in is low, back stage open while it is high.
      tmr_dlatch #(.OPEN_HIGH(1'b0)) front_i (
        .clk(clk), .rst_n(rst_n), .clr_n(clr_n),
        .en(edge_in), .d(d[i]), .q(mid_q[i])
      );
      tmr_dlatch #(.OPEN_HIGH(1'b1)) back_i (
        .clk(clk), .rst_n(rst_n), .clr_n(clr_n),
        .en(edge_in), .d(mid_q[i]), .q(q[i])
      );
    end
  endgenerate
endmodule

// File: rtl/tmr_logic_model.sv
module tmr_logic_model #(
  parameter int FF_W = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            pin_rst_n,
  input  logic            pin_ctl_en,
  input  logic            pin_ctl,
  input  logic            pin_thr,
  input  logic            pin_trg_n,
  output logic            pin_out,
  output logic            pin_dis_oe,
  output logic            pin_dis_lvl,
  input  logic            lat_clr_n,
  input  logic            lat_en,
  input  logic            lat_d,
  output logic            lat_q,
  input  logic            ff_clr_n,
  input  logic            ff_clk,
  input  logic [FF_W-1:0] ff_d,
  output logic [FF_W-1:0] ff_q
);
  // Named request wires of the raw cell, observed by the checker.
  logic raw_set, raw_clr, raw_q;

  tmr_decode raw_dec_i (
    .clr_n  (pin_rst_n),
    .ctl_en (pin_ctl_en),
    .ctl    (pin_ctl),
    .thr    (pin_thr),
    .trg_n  (pin_trg_n),
    .set_req(raw_set),
    .clr_req(raw_clr)
  );

  tmr_srreg raw_reg_i (
    .clk    (clk),
    .rst_n  (rst_n),
    .set_req(raw_set),
    .clr_req(raw_clr),
    .q      (raw_q)
  );

  assign pin_out     = raw_q;
  assign pin_dis_oe  = ~raw_q;   // sink when the state is 0, float otherwise
  assign pin_dis_lvl = 1'b0;

  tmr_dlatch #(.OPEN_HIGH(1'b1)) lat_i (
    .clk(clk), .rst_n(rst_n), .clr_n(lat_clr_n),
    .en(lat_en), .d(lat_d), .q(lat_q)
  );

  tmr_dff_bank #(.W(FF_W)) ff_i (
    .clk(clk), .rst_n(rst_n), .clr_n(ff_clr_n),
    .edge_in(ff_clk), .d(ff_d), .q(ff_q)
  );
endmodule

// File: rtl/tmr_logic_model_chk.sv
module tmr_logic_model_chk (
  input logic clk,
  input logic rst_n,
  input logic pin_rst_n,
  input logic pin_ctl_en,
  input logic pin_ctl,
  input logic pin_thr,
  input logic pin_trg_n,
  input logic pin_out,
  input logic pin_dis_oe,
  input logic cell_set,
  input logic cell_clr,
  input logic lat_clr_n,
  input logic lat_en,
  input logic lat_d,
  input logic lat_q
);
  AST_CLR_PIN_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    !pin_rst_n |=> !pin_out); // R1
  AST_REQ_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    !(cell_set && cell_clr)); // R2
  AST_FLOAT_TRG_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    (pin_rst_n && !pin_ctl_en && !pin_trg_n) |=> pin_out); // R2
  AST_CTL_LO_THR_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (pin_rst_n && pin_ctl_en && !pin_ctl && pin_thr) |=> !pin_out); // R3
  AST_CTL_LO_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (pin_rst_n && pin_ctl_en && !pin_ctl && !pin_thr) |=> $stable(pin_out)); // R3
  AST_CTL_HI_TRG_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    (pin_rst_n && pin_ctl_en && pin_ctl && !pin_trg_n) |=> pin_out); // R4
  AST_CTL_HI_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (pin_rst_n && pin_ctl_en && pin_ctl && pin_trg_n) |=> $stable(pin_out)); // R4
  AST_DIS_FLOATS_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    pin_out |-> !pin_dis_oe); // R6
  AST_LAT_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    (lat_en && lat_clr_n) |=> (lat_q == $past(lat_d))); // R7
  AST_LAT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!lat_en && lat_clr_n) |=> $stable(lat_q)); // R8
  AST_LAT_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    !lat_clr_n |=> !lat_q); // R9
endmodule

bind tmr_logic_model tmr_logic_model_chk chk_i (
  .clk(clk), .rst_n(rst_n),
  .pin_rst_n(pin_rst_n), .pin_ctl_en(pin_ctl_en), .pin_ctl(pin_ctl),
  .pin_thr(pin_thr), .pin_trg_n(pin_trg_n),
  .pin_out(pin_out), .pin_dis_oe(pin_dis_oe),
  .cell_set(raw_set), .cell_clr(raw_clr),
  .lat_clr_n(lat_clr_n), .lat_en(lat_en), .lat_d(lat_d), .lat_q(lat_q)
);

// File: tb/tmr_logic_model_tb.sv
module tmr_logic_model_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int FF_W = 4;
  localparam int WATCHDOG_CYCLES = 100000;

  logic clk = 1'b0;
  logic rst_n;
  logic pin_rst_n, pin_ctl_en, pin_ctl, pin_thr, pin_trg_n;
  logic pin_out, pin_dis_oe, pin_dis_lvl;
  logic lat_clr_n, lat_en, lat_d, lat_q;
  logic ff_clr_n, ff_clk;
  logic [FF_W-1:0] ff_d, ff_q;

  int n_checks = 0;
  int n_bad = 0;
  int cycles = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  tmr_logic_model #(.FF_W(FF_W)) dut_i (
    .clk(clk), .rst_n(rst_n),
    .pin_rst_n(pin_rst_n), .pin_ctl_en(pin_ctl_en), .pin_ctl(pin_ctl),
    .pin_thr(pin_thr), .pin_trg_n(pin_trg_n),
    .pin_out(pin_out), .pin_dis_oe(pin_dis_oe), .pin_dis_lvl(pin_dis_lvl),
    .lat_clr_n(lat_clr_n), .lat_en(lat_en), .lat_d(lat_d), .lat_q(lat_q),
    .ff_clr_n(ff_clr_n), .ff_clk(ff_clk), .ff_d(ff_d), .ff_q(ff_q)
  );

  // Expected next state of the raw cell, written as a truth-table lookup.
  function automatic logic exp_cell(logic [4:0] v, logic q);
    // v = {clr_n, ctl_en, ctl, thr, trg_n}
    logic res;
    casez (v)
      5'b0????: res = 1'b0;
      5'b10??0: res = 1'b1;
      5'b10?11: res = 1'b0;
      5'b10?01: res = q;
      5'b1101?: res = 1'b0;
      5'b1100?: res = q;
      5'b111?0: res = 1'b1;
      default:  res = q;
    endcase
    return res;
  endfunction

  function automatic string req_of(logic [4:0] v);
    if (!v[4]) return "R1";
    if (!v[3]) return "R2";
    if (!v[2]) return "R3";
    return "R4";
  endfunction

  task automatic check(string req, logic [FF_W-1:0] act, logic [FF_W-1:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h at cycle %0d", req, act, exp, cycles);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic drive_pins(logic [4:0] v);
    {pin_rst_n, pin_ctl_en, pin_ctl, pin_thr, pin_trg_n} = v;
  endtask

  task automatic check_dis(logic q_exp);
    logic wired;
    wired = pin_dis_oe ? pin_dis_lvl : 1'b1;   // pull-up resolves the open drain
    check("R6", {3'b0, wired}, {3'b0, q_exp});
    check("R6", {3'b0, pin_dis_lvl}, 4'h0);
  endtask

  task automatic summary();
    $display("  test done: total=%0d bad=%0d", n_checks, n_bad);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > WATCHDOG_CYCLES && !done) begin
      done = 1'b1;
      n_checks++;
      n_bad++;
      $display("FAIL watchdog actual=%0d expected<=%0d", cycles, WATCHDOG_CYCLES);
      summary();
    end
  end

  initial begin
    logic q_exp, lq_exp;
    logic [FF_W-1:0] fq_exp, dv;
    void'($urandom(32'h5eed_0555));
    rst_n = 1'b0;
    drive_pins(5'b10001);
    lat_clr_n = 1'b1; lat_en = 1'b0; lat_d = 1'b0;
    ff_clr_n = 1'b1; ff_clk = 1'b0; ff_d = '0;
    repeat (3) step();
    // R13: reset state
    check("R13", {3'b0, pin_out}, 4'h0);
    check("R13", {3'b0, lat_q}, 4'h0);
    check("R13", ff_q, '0);
    rst_n = 1'b1;
    step();

    // Exhaustive decode from both starting states (R1..R4, R5, R6)
    for (int pre = 0; pre < 2; pre++) begin
      for (int v = 0; v < 32; v++) begin
        drive_pins(pre != 0 ? 5'b10000 : 5'b00111);
        step();
        check("R5", {3'b0, pin_out}, {3'b0, pre[0]});
        drive_pins(v[4:0]);
        step();
        q_exp = exp_cell(v[4:0], pre[0]);
        check(req_of(v[4:0]), {3'b0, pin_out}, {3'b0, q_exp});
        check_dis(q_exp);
      end
    end

    // Random pin sequences on the raw cell
    q_exp = pin_out;
    for (int i = 0; i < 400; i++) begin
      logic [4:0] v;
      v = 5'($urandom);
      if (v[4] == 1'b0 && ($urandom % 4) != 0) v[4] = 1'b1;
      drive_pins(v);
      step();
      q_exp = exp_cell(v, q_exp);
      check(req_of(v), {3'b0, pin_out}, {3'b0, q_exp});
      check_dis(q_exp);
    end

    // Latch mode: directed
    lat_en = 1'b1; lat_d = 1'b1; step();
    check("R7", {3'b0, lat_q}, 4'h1);
    lat_en = 1'b0; lat_d = 1'b0; step(); step();
    check("R8", {3'b0, lat_q}, 4'h1);
    lat_d = 1'b1; step();
    lat_d = 1'b0; step();
    check("R8", {3'b0, lat_q}, 4'h1);
    lat_clr_n = 1'b0; lat_d = 1'b1; step();
    check("R9", {3'b0, lat_q}, 4'h0);
    lat_clr_n = 1'b1; lat_en = 1'b1; lat_d = 1'b0; step();
    check("R7", {3'b0, lat_q}, 4'h0);
    // Latch mode: random
    lq_exp = 1'b0;
    for (int i = 0; i < 300; i++) begin
      lat_en = 1'($urandom);
      lat_d = 1'($urandom);
      lat_clr_n = (($urandom % 8) != 0);
      step();
      if (!lat_clr_n) lq_exp = 1'b0;
      else if (lat_en) lq_exp = lat_d;
      check(!lat_clr_n ? "R9" : (lat_en ? "R7" : "R8"), {3'b0, lat_q}, {3'b0, lq_exp});
    end
    lat_clr_n = 1'b1;

    // Flip-flop bank
    fq_exp = ff_q;
    for (int i = 0; i < 40; i++) begin
      dv = FF_W'($urandom);
      ff_clk = 1'b0; ff_d = dv;
      step(); step();
      check("R11", ff_q, fq_exp);
      ff_clk = 1'b1;
      step();
      fq_exp = dv;
      check("R10", ff_q, fq_exp);
      ff_d = ~dv; step(); step();
      check("R11", ff_q, fq_exp);
      ff_clk = 1'b0; ff_d = FF_W'($urandom);
      step();
      check("R11", ff_q, fq_exp);
    end
    ff_clr_n = 1'b0; step();
    check("R12", ff_q, '0);
    ff_clr_n = 1'b1;

    // R13: asynchronous block reset with state set everywhere
    drive_pins(5'b10000);
    lat_en = 1'b1; lat_d = 1'b1;
    ff_d = '1; ff_clk = 1'b0; step(); step();
    ff_clk = 1'b1; step();
    check("R10", ff_q, '1);
    #(CLK_PERIOD/4);
    rst_n = 1'b0;
    #1;
    check("R13", {3'b0, pin_out}, 4'h0);
    check("R13", {3'b0, lat_q}, 4'h0);
    check("R13", ff_q, '0);
    step();
    rst_n = 1'b1;
    step();

    done = 1'b1;
    summary();
  end
endmodule